// File: doc/BRIEF.md
# Eight-Way Chip-Select Window Decoder

This block turns a 32-bit system-bus address into one of eight one-hot chip selects. Each bank owns one 32-bit window word in a small register space. The word holds a base for address bits 31:17, a care mask over the same bits, and an enable flag, so every window is a power-of-two region aligned to 128 KiB. Each bus cycle marked valid is decoded combinationally against the stored words. The chosen chip select, or a miss flag when nothing claims the address, is registered once.

Two behaviours are inherited from the bus fabric it sits in. First, a strap input sampled during reset exchanges the chip selects of banks 0 and 1, so the boot device can sit on either select. Bank 0's enable flag comes out of reset as the inverse of the strap, which lets software read back which way the strap was set. Second, if the stored word of bank 0 or bank 1 is entirely zero, that bank takes every access regardless of its enable flag and hides all other banks. Software writes all ones to one of these banks to move it out of the way. Banks 2 to 7 are switched off by clearing their enable flag.

Top module: `csel_decoder`

## Requirements
- R1: Bank i's window word is written and read at offset 0x100 + 0x10*i (eight banks). A read returns the written value with bit 16 forced to zero. Bits 31:17 are the base for address bits 31:17, bits 15:1 are the care mask where a 1 means the matching address bit is compared, and bit 0 is the enable.
- R2: An enabled bank matches when every address bit 31:17 whose care bit is 1 equals the corresponding base bit. Address bits 16:0 never affect the decode.
- R3: A bank whose enable bit is 0 and whose word is not the all-zero case of R8 never drives its chip select.
- R4: When several enabled banks match, only the lowest-numbered one drives its chip select, and at most one chip select is ever high.
- R5: A valid access that no bank claims asserts the miss output and no chip select. A cycle with valid low asserts neither.
- R6: The strap level sampled while reset is active decides the mapping. When it is high, bank 0 drives chip select 1 and bank 1 drives chip select 0. When it is low, each bank drives its own select. Strap changes after reset have no effect.
- R7: Reset values are as follows. Bank 0 is 0x00000001 when the strap is low and 0x00000000 when it is high. Bank 1 is 0xFFFEFFFF. Banks 2 to 7 are 0x00000000.
- R8: A stored word of all zeros in bank 0 or bank 1 claims every valid access for that bank, above all window matches. If both are zero, bank 0 wins.
- R9: Bank 0 or 1 holding all ones (read back as 0xFFFEFFFF) claims only the top 128 KiB of the address space.
- R10: The chip select and miss outputs appear one clock after the valid access. An access in the same cycle as a register write decodes with the old word, and the next cycle uses the new one.
- R11: Writes to offsets outside the eight window words change no bank, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap_i | input | 1 | Strap, sampled while reset is active |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| bus_valid_i | input | 1 | Access present this cycle |
| bus_addr_i | input | 32 | Access address |
| cs_o | output | 8 | One-hot chip selects, registered |
| miss_o | output | 1 | No bank claimed the access, registered |

## Verification
Addresses are placed just inside and just outside a 128 KiB window and a 16 MiB window, which separates correct mask handling from an off-by-one in the compared bits. An address claimed by two overlapping enabled banks shows whether priority goes to the lower bank. The same address is sent with a bank disabled, enabled, and rewritten in the same cycle, which shows that the enable is honoured and that a write applies one cycle later. Zeroing bank 1, then both low banks, under both strap levels tells the capture rule apart from the select swap.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 15;          // address bits 31:17
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFFFE_FFFF;
  localparam logic [WORD_W-1:0] PARK_WORD = 32'hFFFE_FFFF;

  typedef logic [WORD_W-1:0] word_t;

  // stored form of a written word: bit 16 is not kept
  function automatic word_t scrub(word_t w);
    return w & KEEP_MASK;
  endfunction

  // window compare: base in 31:17, care bits in 15:1
  function automatic logic win_hit(word_t w, logic [31:0] a);
    logic [FIELD_W-1:0] care;
    care = w[15:1];
    return ((a[31:17] ^ w[31:17]) & care) == '0;
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int N_BANKS  = 8,
  parameter int ADDR_W   = 12,
  parameter int BASE_OFF = 'h100,
  parameter int STRIDE   = 'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boot_swap_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  word_t                  wdata_i,
  output word_t                  rdata_o,
  output word_t [N_BANKS-1:0]    win_o
);
  logic [N_BANKS-1:0] sel;
  word_t [N_BANKS-1:0] win_q;

  for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(BASE_OFF + STRIDE * i);
    word_t rst_val;
    if (i == 0) begin : g_b0
      assign rst_val = {31'd0, ~boot_swap_i};
    end else if (i == 1) begin : g_b1
      assign rst_val = PARK_WORD;
    end else begin : g_bn
      assign rst_val = '0;
    end
    assign sel[i] = (addr_i == OFF);
    always_ff @(posedge clk) begin
      if (!rst_n)                win_q[i] <= rst_val;
      else if (we_i && sel[i])   win_q[i] <= scrub(wdata_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_BANKS; i++) begin
      if (sel[i]) rdata_o = win_q[i];
    end
  end

  assign win_o = win_q;

  // R11: a write that selects no bank leaves every window word untouched
  a_r11_unmapped_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel == '0) |=> $stable(win_q));
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int N_BANKS = 8
) (
  input  word_t [N_BANKS-1:0] win_i,
  input  logic [31:0]         addr_i,
  output logic [N_BANKS-1:0]  hit_o,
  output logic [1:0]          zero_o
);
  for (genvar i = 0; i < N_BANKS; i++) begin : g_hit
    assign hit_o[i] = win_i[i][0] && win_hit(win_i[i], addr_i);
  end

  for (genvar j = 0; j < 2; j++) begin : g_zero
    assign zero_o[j] = (win_i[j] == '0);
  end
endmodule

// File: rtl/csel_pick.sv
module csel_pick #(
  parameter int N_BANKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               swap_i,
  input  logic [N_BANKS-1:0] hit_i,
  input  logic [1:0]         zero_i,
  output logic [N_BANKS-1:0] cs_o,
  output logic               miss_o
);
  logic [N_BANKS-1:0] bank_sel, cs_d;
  logic               claimed;

  always_comb begin
    bank_sel = '0;
    if (zero_i[0])      bank_sel[0] = 1'b1;
    else if (zero_i[1]) bank_sel[1] = 1'b1;
    else begin
      for (int i = N_BANKS - 1; i >= 0; i--) begin
        if (hit_i[i]) bank_sel = N_BANKS'(1) << i;
      end
    end
  end

  assign claimed = |bank_sel;

  always_comb begin
    cs_d = bank_sel;
    if (swap_i) begin
      cs_d[0] = bank_sel[1];
      cs_d[1] = bank_sel[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_o   <= '0;
      miss_o <= 1'b0;
    end else begin
      cs_o   <= valid_i ? cs_d : '0;
      miss_o <= valid_i && !claimed;
    end
  end

  // R4: never more than one select
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));
  // R4: bank 0 hit without capture and without swap lands on select 0
  a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && hit_i[0] && zero_i == 2'b00 && !swap_i) |=> cs_o[0]);
  // R5: miss and select are exclusive; idle cycles assert neither
  a_r5_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> cs_o == '0);
  a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (cs_o == '0 && !miss_o));
  // R8: a zero low bank always claims the access
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && zero_i != 2'b00) |=> (!miss_o && $countones(cs_o) == 1));
  // R6: swapped zero bank 0 drives select 1
  a_r6_swap_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && zero_i[0] && swap_i) |=> cs_o[1]);
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int N_BANKS  = 8,
  parameter int ADDR_W   = 12,
  parameter int BASE_OFF = 'h100,
  parameter int STRIDE   = 'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_swap_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               bus_valid_i,
  input  logic [31:0]        bus_addr_i,
  output logic [N_BANKS-1:0] cs_o,
  output logic               miss_o
);
  logic               swap_q;
  word_t [N_BANKS-1:0] win;
  logic [N_BANKS-1:0] hit;
  logic [1:0]         zero_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) swap_q <= boot_swap_i;
  end

  csel_regs #(
    .N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF), .STRIDE(STRIDE)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .boot_swap_i(boot_swap_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .win_o(win)
  );

  csel_match #(.N_BANKS(N_BANKS)) match_i (
    .win_i(win), .addr_i(bus_addr_i), .hit_o(hit), .zero_o(zero_lo)
  );

  csel_pick #(.N_BANKS(N_BANKS)) pick_i (
    .clk(clk), .rst_n(rst_n), .valid_i(bus_valid_i), .swap_i(swap_q),
    .hit_i(hit), .zero_i(zero_lo), .cs_o(cs_o), .miss_o(miss_o)
  );

  // R6: strap state is frozen once reset is released
  a_r6_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(swap_q));
endmodule

// File: tb/csel_decoder_tb_top.sv
module csel_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        we = 1'b0;
  logic [11:0] raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        valid = 1'b0;
  logic [31:0] baddr = '0;
  logic [7:0]  cs;
  logic        miss;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csel_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .boot_swap_i(strap),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .bus_valid_i(valid), .bus_addr_i(baddr), .cs_o(cs), .miss_o(miss)
  );

  function automatic logic [11:0] off(int b);
    return 12'(32'h100 + 32'h10 * b);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0; valid = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    raddr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic acc(logic [31:0] a, logic [7:0] exp_cs, logic exp_miss, string tag);
    @(negedge clk);
    baddr = a; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " cs"}, {24'd0, cs}, {24'd0, exp_cs});
    chk({tag, " miss"}, {31'd0, miss}, {31'd0, exp_miss});
  endtask

  task automatic t_reset_plain();
    do_reset(1'b0);
    #1;
    chk("R7 cs after reset", {24'd0, cs}, 32'd0);
    rd(off(0), 32'h0000_0001, "R7 bank0 no strap");
    rd(off(1), 32'hFFFE_FFFF, "R7 bank1");
    rd(off(5), 32'h0000_0000, "R7 bank5");
    acc(32'h1234_5678, 8'h01, 1'b0, "R7 bank0 default claims all");
  endtask

  task automatic t_regs();
    wr(off(3), 32'hFFFF_FFFF);
    rd(off(3), 32'hFFFE_FFFF, "R1 bit16 reads zero");
    wr(12'h104, 32'hDEAD_BEEF);
    rd(12'h104, 32'h0, "R11 unmapped read");
    rd(off(3), 32'hFFFE_FFFF, "R11 bank3 untouched");
    wr(off(1), 32'h0001_0000);
    rd(off(1), 32'h0, "R1 bit16 only stores zero");
  endtask

  task automatic setup_windows();
    wr(off(0), 32'h0000_FFFF);   // 0x0000_0000, 128 KiB
    wr(off(1), 32'hFFFF_FFFF);   // parked
    wr(off(2), 32'h1000_FF01);   // 0x1000_0000, 16 MiB
    wr(off(3), 32'h1080_FFFF);   // 0x1080_0000, 128 KiB
    wr(off(4), 32'h2000_FFFE);   // disabled
  endtask

  task automatic t_windows();
    setup_windows();
    acc(32'h0001_0000, 8'h01, 1'b0, "R2 inside 128K");
    acc(32'h0002_0000, 8'h00, 1'b1, "R2 just past 128K");
    acc(32'h10FF_FFFC, 8'h04, 1'b0, "R2 top of 16M");
    acc(32'h1100_0000, 8'h00, 1'b1, "R5 past 16M miss");
    acc(32'h1080_0004, 8'h04, 1'b0, "R4 lowest overlap wins");
    acc(32'h2000_0000, 8'h00, 1'b1, "R3 disabled bank");
    wr(off(4), 32'h2000_FFFF);
    acc(32'h2000_0000, 8'h10, 1'b0, "R3 enabled bank");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    we = 1'b1; raddr = off(4); wdata = 32'h2000_FFFE;
    baddr = 32'h2000_0000; valid = 1'b1;
    @(negedge clk);
    we = 1'b0; valid = 1'b0;
    chk("R10 old word same cycle", {24'd0, cs}, 32'h10);
    acc(32'h2000_0000, 8'h00, 1'b1, "R10 new word next cycle");
  endtask

  task automatic t_park_idle();
    acc(32'hFFFE_0000, 8'h02, 1'b0, "R9 top 128K");
    acc(32'hFFFD_FFFC, 8'h00, 1'b1, "R9 below top");
    @(negedge clk);
    baddr = 32'h0; valid = 1'b0;
    @(negedge clk);
    chk("R5 idle cs", {24'd0, cs}, 32'd0);
    chk("R5 idle miss", {31'd0, miss}, 32'd0);
  endtask

  task automatic t_capture();
    wr(off(1), 32'h0);
    acc(32'h1000_0000, 8'h02, 1'b0, "R8 zero bank1 captures");
    wr(off(0), 32'h0);
    acc(32'h1000_0000, 8'h01, 1'b0, "R8 bank0 over bank1");
  endtask

  task automatic t_swap();
    do_reset(1'b1);
    rd(off(0), 32'h0000_0000, "R7 bank0 with strap");
    acc(32'h3000_0000, 8'h02, 1'b0, "R6 swapped capture");
    wr(off(0), 32'h0000_FFFF);
    wr(off(1), 32'h1000_FF01);
    acc(32'h0000_0000, 8'h02, 1'b0, "R6 bank0 on cs1");
    acc(32'h1000_0000, 8'h01, 1'b0, "R6 bank1 on cs0");
    @(negedge clk);
    strap = 1'b0;
    acc(32'h0000_0000, 8'h02, 1'b0, "R6 strap ignored after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_plain();
    t_regs();
    t_windows();
    t_same_cycle();
    t_park_idle();
    t_capture();
    t_swap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule